// File: doc/BRIEF.md
# Boundary-Midpoint Level Estimator

This block turns a monobit threshold sweep into a per-phase level estimate. Each sample arrives as a phase index, a threshold code and the one-bit comparator decision taken at that threshold. For every phase the block records two running extrema. The first is the highest threshold at which the comparator reported a 1. The second is the lowest threshold at which it reported a 0. The signal level lies between these two values, so the block reports their midpoint.

The extrema keep accumulating across as many sweeps as are fed in, until a synchronous clear returns every phase to its empty state. A sample can move an estimate only when it pushes one of the extrema further out. A registered read port takes a phase index and, one cycle later, returns that phase's midpoint and a flag that says whether the midpoint is meaningful. The midpoint carries one fractional bit, so a half-code result is kept exactly.

Top module: `mmb_boundary_est`

## Requirements
- R1: After a synchronous active-low reset or a clear, every phase reads back with `rd_valid` = 0 and `rd_est` = 0.
- R2: A sample with bit = 1 raises that phase's max-of-ones to the sample threshold when no 1 has been seen yet or the threshold is above the stored value.
- R3: A sample with bit = 0 lowers that phase's min-of-zeros to the sample threshold when no 0 has been seen yet or the threshold is below the stored value.
- R4: A sample that does not extend the relevant extreme (a 1 at or below max-of-ones, or a 0 at or above min-of-zeros) leaves the estimate unchanged.
- R5: `rd_valid` is 1 only when that phase has seen at least one 1 and at least one 0. While `rd_valid` is 0, `rd_est` is 0.
- R6: When valid, `rd_est` equals max-of-ones plus min-of-zeros, THR_W+1 bits wide. Bit 0 is the half-code fraction, so the integer part is `rd_est[THR_W:1]`.
- R7: Each phase keeps its own state. A sample to one phase never changes another phase's estimate.
- R8: `clr` empties all phases on the next clock edge. A sample in the same cycle as `clr` is dropped.
- R9: `rd_est`/`rd_valid` register the state of phase `rd_phase` one edge after it is presented. If a sample updates that phase on the same edge, the read returns the state from before that update.
- R10: A sample whose phase index is NUM_PHASES or more is dropped. A read of such an index returns `rd_valid` = 0 and `rd_est` = 0.
- R11: With `smp_valid` = 0, no phase state changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clr | input | 1 | Synchronous clear of all phases |
| smp_valid | input | 1 | Qualifies the sample fields |
| smp_phase | input | PH_W | Sampling-phase index of the sample |
| smp_thr | input | THR_W | Threshold code of the sample |
| smp_bit | input | 1 | Comparator decision (1 = signal at or above threshold) |
| rd_phase | input | PH_W | Phase to read |
| rd_est | output | THR_W+1 | Midpoint sum, LSB is one half code |
| rd_valid | output | 1 | Phase has seen both a 1 and a 0 |

## Verification
The bench builds the block with NUM_PHASES = 5 and THR_W = 4. Because 5 is not a power of two, the 3-bit phase index can name phases 5 to 7, which do not exist. That makes the drop-and-read-invalid behaviour of out-of-range indices reachable. The 4-bit codes make the extreme thresholds 0 and 15 easy to reach, including a first 1 at code 0 and a first 0 at code 15, which equal the cleared register values. They also make odd midpoint sums with a half-code fraction easy to produce.

// File: rtl/mmb_pkg.sv
// Package mmb_pkg
// Shared types and helpers for the boundary-midpoint estimator.
// Assumes threshold codes are unsigned, with a larger code meaning a higher level.
package mmb_pkg;

    // Per-phase observation flags
    typedef struct packed {
        logic seen_one;
        logic seen_zero;
    } mmb_flags_t;

    // True when a new code pushes an extremum outward.
    // For the ones side the extremum grows; for the zeros side it shrinks.
    function automatic logic mmb_extends(
        input logic        upward,
        input logic        seen,
        input logic [31:0] cand,
        input logic [31:0] cur
    );
        if (!seen)
            return 1'b1;
        if (upward)
            return cand > cur;
        return cand < cur;
    endfunction

endpackage

// File: rtl/mmb_wr_decode.sv
// Module mmb_wr_decode
// Turns a qualified sample into a one-hot write strobe per phase.
// Assumes indices at or above NUM_PHASES match no strobe, which drops the sample.
// A clear suppresses every strobe, so a sample in a clear cycle is dropped.
module mmb_wr_decode #(
    parameter int NUM_PHASES = 5,
    parameter int PH_W       = (NUM_PHASES > 1) ? $clog2(NUM_PHASES) : 1
) (
    input  logic                  smp_valid,
    input  logic                  clr,
    input  logic [PH_W-1:0]       smp_phase,
    output logic [NUM_PHASES-1:0] wr_en
);

    // One comparator per phase slot
    for (genvar g = 0; g < NUM_PHASES; g++) begin : g_dec
        always_comb wr_en[g] = smp_valid && !clr && (smp_phase == PH_W'(g));
    end

endmodule

// File: rtl/mmb_phase_cell.sv
// Module mmb_phase_cell
// Holds the state of one sampling phase: the highest code that gave a 1,
// the lowest code that gave a 0, and a seen flag for each side.
// Assumes clear takes precedence over a write in the same cycle.
// Cleared values: max-of-ones = 0, min-of-zeros = all ones.
module mmb_phase_cell #(
    parameter int THR_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             wr_en,
    input  logic [THR_W-1:0] thr,
    input  logic             cmp_bit,
    output logic [THR_W-1:0] max_one,
    output logic [THR_W-1:0] min_zero,
    output mmb_pkg::mmb_flags_t flags
);
    import mmb_pkg::*;

    localparam logic [THR_W-1:0] CODE_LO = '0;
    localparam logic [THR_W-1:0] CODE_HI = '1;

    logic upd_one;
    logic upd_zero;

    // Decide whether this sample extends one of the two extrema
    always_comb begin
        upd_one  = wr_en &&  cmp_bit &&
                   mmb_extends(1'b1, flags.seen_one,  32'(thr), 32'(max_one));
        upd_zero = wr_en && !cmp_bit &&
                   mmb_extends(1'b0, flags.seen_zero, 32'(thr), 32'(min_zero));
    end

    // Max-of-ones side register
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            max_one        <= CODE_LO;
            flags.seen_one <= 1'b0;
        end else if (upd_one) begin
            max_one        <= thr;
            flags.seen_one <= 1'b1;
        end
    end

    // Min-of-zeros side register
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            min_zero        <= CODE_HI;
            flags.seen_zero <= 1'b0;
        end else if (upd_zero) begin
            min_zero        <= thr;
            flags.seen_zero <= 1'b1;
        end
    end

endmodule

// File: rtl/mmb_read_port.sv
// Module mmb_read_port
// Selects one phase and registers its midpoint and validity.
// Assumes the cell state it sees is the state before any same-edge update,
// which gives read-before-write ordering.
// The midpoint is kept as a THR_W+1-bit sum, whose LSB is the half-code fraction.
module mmb_read_port #(
    parameter int NUM_PHASES = 5,
    parameter int THR_W      = 4,
    parameter int PH_W       = (NUM_PHASES > 1) ? $clog2(NUM_PHASES) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [PH_W-1:0]     rd_phase,
    input  logic [THR_W-1:0]    max_one  [NUM_PHASES],
    input  logic [THR_W-1:0]    min_zero [NUM_PHASES],
    input  mmb_pkg::mmb_flags_t flags    [NUM_PHASES],
    output logic [THR_W:0]      rd_est,
    output logic                rd_valid
);
    import mmb_pkg::*;

    localparam logic [PH_W:0] PH_LIMIT = (PH_W+1)'(NUM_PHASES);

    logic             in_range;
    logic [THR_W-1:0] sel_max;
    logic [THR_W-1:0] sel_min;
    mmb_flags_t       sel_flags;
    logic             nxt_valid;
    logic [THR_W:0]   nxt_est;

    // Mux the addressed phase, with out-of-range indices selecting empty state
    always_comb begin
        in_range  = {1'b0, rd_phase} < PH_LIMIT;
        sel_max   = '0;
        sel_min   = '0;
        sel_flags = '0;
        for (int i = 0; i < NUM_PHASES; i++) begin
            if (in_range && rd_phase == PH_W'(i)) begin
                sel_max   = max_one[i];
                sel_min   = min_zero[i];
                sel_flags = flags[i];
            end
        end
    end

    // Form the midpoint sum and gate it with validity
    always_comb begin
        nxt_valid = sel_flags.seen_one && sel_flags.seen_zero;
        nxt_est   = nxt_valid ? ({1'b0, sel_max} + {1'b0, sel_min}) : '0;
    end

    // Output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_est   <= '0;
            rd_valid <= 1'b0;
        end else begin
            rd_est   <= nxt_est;
            rd_valid <= nxt_valid;
        end
    end

endmodule

// File: rtl/mmb_boundary_est.sv
// Module mmb_boundary_est
// Top of the boundary-midpoint level estimator. Samples of
// (phase, threshold, bit) feed per-phase extremum cells, and a registered
// read port returns the midpoint of the chosen phase.
// Assumes one sample per cycle at most, and a synchronous active-low reset.
module mmb_boundary_est #(
    parameter int NUM_PHASES = 5,
    parameter int THR_W      = 4,
    localparam int PH_W      = (NUM_PHASES > 1) ? $clog2(NUM_PHASES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              smp_valid,
    input  logic [PH_W-1:0]   smp_phase,
    input  logic [THR_W-1:0]  smp_thr,
    input  logic              smp_bit,
    input  logic [PH_W-1:0]   rd_phase,
    output logic [THR_W:0]    rd_est,
    output logic              rd_valid
);
    import mmb_pkg::*;

    logic [NUM_PHASES-1:0] wr_en;
    logic [THR_W-1:0]      cell_max  [NUM_PHASES];
    logic [THR_W-1:0]      cell_min  [NUM_PHASES];
    mmb_flags_t            cell_flag [NUM_PHASES];

    mmb_wr_decode #(
        .NUM_PHASES (NUM_PHASES),
        .PH_W       (PH_W)
    ) u_dec (
        .smp_valid (smp_valid),
        .clr       (clr),
        .smp_phase (smp_phase),
        .wr_en     (wr_en)
    );

    // One state cell per sampling phase
    for (genvar g = 0; g < NUM_PHASES; g++) begin : g_cell
        mmb_phase_cell #(
            .THR_W (THR_W)
        ) u_cell (
            .clk      (clk),
            .rst_n    (rst_n),
            .clr      (clr),
            .wr_en    (wr_en[g]),
            .thr      (smp_thr),
            .cmp_bit  (smp_bit),
            .max_one  (cell_max[g]),
            .min_zero (cell_min[g]),
            .flags    (cell_flag[g])
        );
    end

    mmb_read_port #(
        .NUM_PHASES (NUM_PHASES),
        .THR_W      (THR_W),
        .PH_W       (PH_W)
    ) u_rd (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_phase (rd_phase),
        .max_one  (cell_max),
        .min_zero (cell_min),
        .flags    (cell_flag),
        .rd_est   (rd_est),
        .rd_valid (rd_valid)
    );

endmodule

// File: rtl/mmb_boundary_est_chk.sv
// Module mmb_boundary_est_chk
// Port-level properties for mmb_boundary_est, bound onto every instance.
module mmb_boundary_est_chk #(
    parameter int NUM_PHASES = 5,
    parameter int THR_W      = 4,
    parameter int PH_W       = (NUM_PHASES > 1) ? $clog2(NUM_PHASES) : 1
) (
    input logic            clk,
    input logic            rst_n,
    input logic            clr,
    input logic            smp_valid,
    input logic [PH_W-1:0] rd_phase,
    input logic [THR_W:0]  rd_est,
    input logic            rd_valid
);

    localparam logic [PH_W:0] PH_LIMIT = (PH_W+1)'(NUM_PHASES);

    // R5: an invalid read carries a zero estimate
    a_r5_invalid_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_valid |-> rd_est == '0);

    // R8: after a clear edge, the next read reflects empty state
    a_r8_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> ##1 !rd_valid);

    // R10: a read of a phase that does not exist comes back empty
    a_r10_bad_phase_read: assert property (@(posedge clk) disable iff (!rst_n)
        ({1'b0, rd_phase} >= PH_LIMIT) |=> (!rd_valid && rd_est == '0));

    // R11: with no write and the same read phase, the read result holds
    a_r11_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n, 2) && $past(rst_n) && !$past(smp_valid, 2) && !$past(clr, 2)
         && $past(rd_phase) == $past(rd_phase, 2))
        |-> ($stable(rd_est) && $stable(rd_valid)));

endmodule

bind mmb_boundary_est mmb_boundary_est_chk #(
    .NUM_PHASES (NUM_PHASES),
    .THR_W      (THR_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (clr),
    .smp_valid (smp_valid),
    .rd_phase  (rd_phase),
    .rd_est    (rd_est),
    .rd_valid  (rd_valid)
);

// File: tb/mmb_boundary_est_tb.sv
module mmb_boundary_est_tb;

    localparam int NP   = 5;
    localparam int TW   = 4;
    localparam int PW   = 3;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          clr;
    logic          smp_valid;
    logic [PW-1:0] smp_phase;
    logic [TW-1:0] smp_thr;
    logic          smp_bit;
    logic [PW-1:0] rd_phase;
    logic [TW:0]   rd_est;
    logic          rd_valid;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    mmb_boundary_est #(.NUM_PHASES(NP), .THR_W(TW)) u_dut (
        .clk, .rst_n, .clr, .smp_valid, .smp_phase, .smp_thr, .smp_bit,
        .rd_phase, .rd_est, .rd_valid
    );

    typedef struct packed {
        logic [3:0]    req;
        logic          c;
        logic          v;
        logic [PW-1:0] ph;
        logic [TW-1:0] thr;
        logic          b;
        logic [PW-1:0] rp;
        logic          ev;
        logic [TW:0]   ee;
    } vec_t;

    localparam int NV = 25;
    // Each row: write + read in one cycle; expected read = state before the write
    localparam vec_t VECS [NV] = '{
        '{4'd1,  1'b0,1'b1,3'd0,4'd5, 1'b1,3'd0,1'b0,5'd0 },  // R1 empty phase 0
        '{4'd5,  1'b0,1'b1,3'd0,4'd9, 1'b0,3'd0,1'b0,5'd0 },  // R5 only a one seen
        '{4'd6,  1'b0,1'b0,3'd0,4'd0, 1'b1,3'd0,1'b1,5'd14},  // R6 5+9
        '{4'd9,  1'b0,1'b1,3'd0,4'd7, 1'b1,3'd0,1'b1,5'd14},  // R9 pre-write value
        '{4'd2,  1'b0,1'b1,3'd0,4'd6, 1'b1,3'd0,1'b1,5'd16},  // R2 max rose to 7
        '{4'd4,  1'b0,1'b1,3'd0,4'd8, 1'b0,3'd0,1'b1,5'd16},  // R4 the 6 was ignored
        '{4'd3,  1'b0,1'b1,3'd0,4'd12,1'b0,3'd0,1'b1,5'd15},  // R3 min fell to 8, half-code
        '{4'd4,  1'b0,1'b1,3'd3,4'd2, 1'b0,3'd0,1'b1,5'd15},  // R4 the zero at 12 ignored
        '{4'd7,  1'b0,1'b1,3'd3,4'd2, 1'b1,3'd3,1'b0,5'd0 },  // R7 phase 3 zeros only
        '{4'd7,  1'b0,1'b1,3'd1,4'd15,1'b1,3'd3,1'b1,5'd4 },  // R7 phase 3 = 2+2
        '{4'd5,  1'b0,1'b1,3'd1,4'd0, 1'b0,3'd1,1'b0,5'd0 },  // R5 phase 1 ones only
        '{4'd11, 1'b0,1'b0,3'd1,4'd9, 1'b1,3'd1,1'b1,5'd15},  // R11 15+0
        '{4'd11, 1'b0,1'b1,3'd4,4'd3, 1'b1,3'd1,1'b1,5'd15},  // R11 idle kept phase 1
        '{4'd7,  1'b0,1'b1,3'd5,4'd4, 1'b0,3'd0,1'b1,5'd15},  // R7 phase 0 untouched
        '{4'd10, 1'b0,1'b0,3'd0,4'd0, 1'b0,3'd4,1'b0,5'd0 },  // R10 phase 5 write dropped
        '{4'd10, 1'b0,1'b1,3'd4,4'd10,1'b0,3'd5,1'b0,5'd0 },  // R10 phase 5 read empty
        '{4'd10, 1'b0,1'b0,3'd0,4'd0, 1'b0,3'd7,1'b0,5'd0 },  // R10 phase 7 read empty
        '{4'd6,  1'b0,1'b0,3'd0,4'd0, 1'b0,3'd4,1'b1,5'd13},  // R6 3+10
        '{4'd8,  1'b1,1'b1,3'd0,4'd15,1'b1,3'd0,1'b1,5'd15},  // R8 clear with a sample
        '{4'd8,  1'b0,1'b1,3'd0,4'd3, 1'b0,3'd0,1'b0,5'd0 },  // R8 cleared
        '{4'd8,  1'b0,1'b1,3'd0,4'd4, 1'b1,3'd0,1'b0,5'd0 },  // R8 the clear-cycle one was dropped
        '{4'd6,  1'b0,1'b1,3'd2,4'd0, 1'b1,3'd0,1'b1,5'd7 },  // R6 4+3
        '{4'd2,  1'b0,1'b1,3'd2,4'd15,1'b0,3'd2,1'b0,5'd0 },  // R2 first one at code 0
        '{4'd3,  1'b0,1'b0,3'd0,4'd0, 1'b0,3'd2,1'b1,5'd15},  // R3 first zero at code 15
        '{4'd1,  1'b0,1'b0,3'd0,4'd0, 1'b0,3'd3,1'b0,5'd0 }   // R1 phase 3 empty after clear
    };

    task automatic check(input string req, input logic ev, input logic [TW:0] ee);
        n_run++;
        if (rd_valid !== ev || rd_est !== ee) begin
            n_fail++;
            $display("FAIL %s: valid=%0b est=%0d, expected valid=%0b est=%0d",
                     req, rd_valid, rd_est, ev, ee);
        end
    endtask

    task automatic drive(input vec_t vv);
        clr = vv.c; smp_valid = vv.v; smp_phase = vv.ph;
        smp_thr = vv.thr; smp_bit = vv.b; rd_phase = vv.rp;
    endtask

    task automatic idle;
        clr = 1'b0; smp_valid = 1'b0; smp_phase = '0;
        smp_thr = '0; smp_bit = 1'b0;
    endtask

    // Watchdog
    initial begin
        #400000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not finish");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; idle(); rd_phase = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state of every phase
        for (int p = 0; p < NP; p++) begin
            rd_phase = PW'(p);
            @(negedge clk);
            check($sformatf("R1 reset phase %0d", p), 1'b0, '0);
        end
        // Table walk
        for (int i = 0; i < NV; i++) begin
            drive(VECS[i]);
            @(negedge clk);
            check($sformatf("R%0d row %0d", VECS[i].req, i), VECS[i].ev, VECS[i].ee);
        end
        idle();
        // R1: reset in mid-run empties a filled phase
        drive('{4'd1, 1'b0,1'b1,3'd1,4'd6,1'b0,3'd1,1'b0,5'd0});
        @(negedge clk);
        drive('{4'd1, 1'b0,1'b1,3'd1,4'd2,1'b1,3'd1,1'b0,5'd0});
        @(negedge clk);
        idle();
        @(negedge clk);
        check("R6 phase 1 = 2+6", 1'b1, 5'd8);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset clears phase 1", 1'b0, '0);
        // R4: repeated ones at equal code leave estimate
        drive('{4'd4, 1'b0,1'b1,3'd1,4'd9,1'b1,3'd1,1'b0,5'd0});
        @(negedge clk);
        drive('{4'd4, 1'b0,1'b1,3'd1,4'd11,1'b0,3'd1,1'b0,5'd0});
        @(negedge clk);
        drive('{4'd4, 1'b0,1'b1,3'd1,4'd9,1'b1,3'd1,1'b1,5'd20});
        @(negedge clk);
        idle();
        @(negedge clk);
        check("R4 equal code no change", 1'b1, 5'd20);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule